// File: doc/BRIEF.md
# Banked Register Address Decoder

This block is the register front of a user logic region. It receives 32-bit transfers on a simple register bus whose 14-bit address counts 32-bit words, so software byte addresses arrive shifted right by two. Only one 1024-word region (by default software 0x8000 to 0x8FFF, word 0x2000 to 0x23FF) is claimed. Inside that region, word-address bits [9:6] pick a bank of 64 words and bits [5:0] pick a word inside the bank. As a result, hex digit 2 of the software byte address names the bank.

Banks 0 to 6 belong to system functions, and 5 and 6 are reserved. None of them is implemented here. Banks 7 to 9 are user space, and this block implements the user bank 7. Its low offsets hold control words that software writes and user logic reads. The offsets directly after them hold status words that user logic drives and software reads. Bit 0 of the third control word is brought out as a level-sensitive reset for the timestamp counters. That reset is held for as long as the bit stays 1.

Read data is registered: it appears one clock after the read strobe and holds until the next strobe. Everything outside the implemented words reads as zero and ignores writes.

Top module: `regbank_decoder`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every control word, `ctrl_out`, `ts_reset` and `rdata` are zero.
- R2: A write strobe at word address 0x21C0+k (software 0x8700+4k) for k = 0..3 loads `wdata` into control word k. The new value is visible on `ctrl_out[32k+31:32k]` after that clock edge.
- R3: A read strobe at word 0x21C0+k returns control word k on `rdata` one clock later. While the read strobe is low, `rdata` keeps its value.
- R4: A read strobe at word 0x21C4+j (software 0x8710+4j, j = 0..3) returns `status_in[32j+31:32j]` as sampled on the strobe's clock edge, one clock later.
- R5: Writes to the status words (word 0x21C4 to 0x21C7) change no control word.
- R6: Reads of any address in the region that is not one of the eight words above return 0x00000000, and writes to them change no control word. This covers other banks and bank 7 offsets 8 to 63.
- R7: `ts_reset` equals bit 0 of control word 2 (word 0x21C2, software 0x8708). It stays high for as long as that bit holds 1.
- R8: Only word addresses whose bits [13:10] equal 4'b1000 are decoded. An address with the user bank and offset in bits [9:0] but other upper bits reads as zero and writes nothing.
- R9: When a read strobe and a write strobe hit the same control word in the same cycle, `rdata` returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 14 | Word address (software byte address >> 2) |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, data one cycle later |
| rdata | output | 32 | Registered read data |
| status_in | input | 128 | Four status words from user logic, word j in bits [32j+31:32j] |
| ctrl_out | output | 128 | Four control words to user logic, word k in bits [32k+31:32k] |
| ts_reset | output | 1 | Timestamp counter reset, level sensitive |

## Verification
The bench builds the block with its default parameters: four control words, four status words, the region at word 0x2000, the user bank at 7 and the reset bit at word 2, bit 0. With these values the full user bank is reachable, along with both neighbouring banks, the last offset of bank 7, and aliases of the bank 7 offsets in other 1024-word regions. Every clock, the bench compares `ctrl_out`, `ts_reset` and `rdata` against a model that decodes software byte addresses on its own. This includes a read and a write to one word in the same cycle, and a reset taken in the middle of the run.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

  // Fixed split of the word address below the region bits
  localparam int OFF_W    = 6;
  localparam int BANK_LSB = OFF_W;
  localparam int BANK_W   = 4;

  // Decoded selection for one bus cycle
  typedef struct packed {
    logic             hit_rw;  // a control word is addressed
    logic             hit_ro;  // a status word is addressed
    logic [OFF_W-1:0] idx;     // word index within its group
  } sel_t;

endpackage

// File: rtl/regdec_decode.sv
module regdec_decode
  import regdec_pkg::*;
#(
  parameter int unsigned    ADDR_W     = 14,
  parameter logic [13:0]    BASE_WADDR = 14'h2000,
  parameter int unsigned    USER_BANK  = 7,
  parameter int unsigned    NUM_RW     = 4,
  parameter int unsigned    NUM_RO     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);

  localparam int REG_LSB = BANK_LSB + BANK_W;
  localparam int REG_W   = ADDR_W - REG_LSB;

  logic [REG_W-1:0]  region_bits;
  logic [BANK_W-1:0] bank_bits;
  logic [OFF_W-1:0]  off_bits;
  logic [31:0]       off_ext;
  logic              region_hit;
  logic              bank_hit;
  logic              rw_range;
  logic              ro_range;

  assign region_bits = addr[ADDR_W-1:REG_LSB];
  assign bank_bits   = addr[REG_LSB-1:BANK_LSB];
  assign off_bits    = addr[OFF_W-1:0];
  assign off_ext     = {{(32-OFF_W){1'b0}}, off_bits};

  always_comb begin
    region_hit = (region_bits == BASE_WADDR[ADDR_W-1:REG_LSB]);
    bank_hit   = (bank_bits == BANK_W'(USER_BANK));
    rw_range   = (off_ext < NUM_RW);
    ro_range   = (off_ext >= NUM_RW) && (off_ext < (NUM_RW + NUM_RO));
  end

  always_comb begin
    sel.hit_rw = region_hit && bank_hit && rw_range;
    sel.hit_ro = region_hit && bank_hit && ro_range;
    if (rw_range) sel.idx = off_bits;
    else          sel.idx = off_bits - OFF_W'(NUM_RW);
  end

endmodule

// File: rtl/regdec_rw_bank.sv
module regdec_rw_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RW-1:0]        we,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NUM_RW*DATA_W-1:0] q_flat
);

  for (genvar k = 0; k < NUM_RW; k++) begin : g_word
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    // next-state
    always_comb begin
      d = q;
      if (we[k]) d = wdata;
    end

    // register with explicit enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[k]) q <= d;
    end

    assign q_flat[k*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/regdec_rd_mux.sv
module regdec_rd_mux
  import regdec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RW = 4,
  parameter int unsigned NUM_RO = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  sel_t                     sel,
  input  logic [NUM_RW*DATA_W-1:0] rw_flat,
  input  logic [NUM_RO*DATA_W-1:0] ro_flat,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  // select the addressed word; anything unmatched stays zero
  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_RW; k++) begin
      if (sel.hit_rw && (sel.idx == OFF_W'(k))) pick = rw_flat[k*DATA_W +: DATA_W];
    end
    for (int j = 0; j < NUM_RO; j++) begin
      if (sel.hit_ro && (sel.idx == OFF_W'(j))) pick = ro_flat[j*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/regbank_decoder.sv
module regbank_decoder
  import regdec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter logic [13:0] BASE_WADDR = 14'h2000,
  parameter int unsigned USER_BANK  = 7,
  parameter int unsigned NUM_RW     = 4,
  parameter int unsigned NUM_RO     = 4,
  parameter int unsigned TSR_REG    = 2,
  parameter int unsigned TSR_BIT    = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_RO*DATA_W-1:0] status_in,
  output logic [NUM_RW*DATA_W-1:0] ctrl_out,
  output logic                     ts_reset
);

  localparam int TSR_POS = TSR_REG * DATA_W + TSR_BIT;

  sel_t                     sel;
  logic [NUM_RW-1:0]        we;
  logic [NUM_RW*DATA_W-1:0] rw_flat;

  regdec_decode #(
    .ADDR_W     (ADDR_W),
    .BASE_WADDR (BASE_WADDR),
    .USER_BANK  (USER_BANK),
    .NUM_RW     (NUM_RW),
    .NUM_RO     (NUM_RO)
  ) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  // one write enable per control word; status words get none
  for (genvar k = 0; k < NUM_RW; k++) begin : g_we
    assign we[k] = wr_en && sel.hit_rw && (sel.idx == OFF_W'(k));
  end

  regdec_rw_bank #(
    .DATA_W (DATA_W),
    .NUM_RW (NUM_RW)
  ) u_rw_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (we),
    .wdata  (wdata),
    .q_flat (rw_flat)
  );

  regdec_rd_mux #(
    .DATA_W (DATA_W),
    .NUM_RW (NUM_RW),
    .NUM_RO (NUM_RO)
  ) u_rd_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .sel     (sel),
    .rw_flat (rw_flat),
    .ro_flat (status_in),
    .rdata   (rdata)
  );

  assign ctrl_out = rw_flat;
  assign ts_reset = rw_flat[TSR_POS];

endmodule

// File: rtl/regdec_chk.sv
module regdec_chk #(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned DATA_W     = 32,
  parameter logic [13:0] BASE_WADDR = 14'h2000,
  parameter int unsigned USER_BANK  = 7,
  parameter int unsigned NUM_RW     = 4,
  parameter int unsigned NUM_RO     = 4,
  parameter int unsigned TSR_REG    = 2,
  parameter int unsigned TSR_BIT    = 0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        wdata,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [DATA_W-1:0]        rdata,
  input logic [NUM_RW*DATA_W-1:0] ctrl_out,
  input logic                     ts_reset
);

  localparam logic [ADDR_W-1:0] UBASE =
    (ADDR_W'(BASE_WADDR) & ~ADDR_W'(1023)) | ADDR_W'(USER_BANK * 64);
  localparam logic [ADDR_W-1:0] A_RW_LAST = UBASE + ADDR_W'(NUM_RW - 1);
  localparam logic [ADDR_W-1:0] A_TSR     = UBASE + ADDR_W'(TSR_REG);
  localparam logic [ADDR_W-1:0] A_RO_LO   = UBASE + ADDR_W'(NUM_RW);
  localparam logic [ADDR_W-1:0] A_END     = UBASE + ADDR_W'(NUM_RW + NUM_RO);

  logic is_rw0, is_rw_last, is_tsr, is_ro, is_mapped;
  assign is_rw0     = (addr == UBASE);
  assign is_rw_last = (addr == A_RW_LAST);
  assign is_tsr     = (addr == A_TSR);
  assign is_ro      = (addr >= A_RO_LO) && (addr < A_END);
  assign is_mapped  = (addr >= UBASE) && (addr < A_END);

  // R2
  rw_first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_rw0) |=> (ctrl_out[DATA_W-1:0] == $past(wdata)));

  // R2
  rw_last_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_rw_last) |=> (ctrl_out[(NUM_RW-1)*DATA_W +: DATA_W] == $past(wdata)));

  // R7
  ts_reset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_tsr) |=> (ts_reset == $past(wdata[TSR_BIT])));

  // R7
  ts_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && is_tsr) |=> $stable(ts_reset));

  // R5
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ro) |=> $stable(ctrl_out));

  // R6
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_mapped) |=> $stable(ctrl_out));

  // R6
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mapped) |=> (rdata == '0));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind regbank_decoder regdec_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BASE_WADDR (BASE_WADDR),
  .USER_BANK  (USER_BANK),
  .NUM_RW     (NUM_RW),
  .NUM_RO     (NUM_RO),
  .TSR_REG    (TSR_REG),
  .TSR_BIT    (TSR_BIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wdata    (wdata),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .ctrl_out (ctrl_out),
  .ts_reset (ts_reset)
);

// File: tb/regbank_decoder_test.sv
`timescale 1ns/1ps
module regbank_decoder_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [13:0]  addr;
  logic [31:0]  wdata;
  logic         wr_en;
  logic         rd_en;
  logic [31:0]  rdata;
  logic [127:0] status_in;
  logic [127:0] ctrl_out;
  logic         ts_reset;

  always #10 clk = ~clk;  // 50 MHz

  regbank_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .status_in(status_in),
    .ctrl_out(ctrl_out), .ts_reset(ts_reset)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  string cur_req  = "R1";
  int    cur_sw   = 0;

  // behavioural reference, keyed on software byte addresses
  logic [31:0] m_ctl [4];
  logic [31:0] m_rdata;

  function automatic logic [31:0] exp_read(int sw);
    int bank, off;
    if (sw < 'h8000 || sw > 'h8FFF) return 32'h0;
    bank = (sw >> 8) & 'hF;
    off  = (sw & 'hFF) >> 2;
    if (bank != 7) return 32'h0;
    if (off < 4) return m_ctl[off];
    if (off < 8) return status_in[(off-4)*32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_ctl[k] = 32'h0;
      m_rdata = 32'h0;
    end else begin
      if (rd_en) m_rdata = exp_read(cur_sw);
      if (wr_en && cur_sw >= 'h8700 && cur_sw <= 'h870C) m_ctl[(cur_sw & 'hF) >> 2] = wdata;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      for (int k = 0; k < 4; k++) chk(cur_req, "ctrl_out word", ctrl_out[k*32 +: 32], m_ctl[k]);
      chk(cur_req, "ts_reset (R7)", {31'b0, ts_reset}, {31'b0, m_ctl[2][0]});
      chk(cur_req, "rdata", rdata, m_rdata);
    end
  end

  task automatic op(int sw, bit we, logic [31:0] wd, bit re, string tag);
    @(negedge clk);
    cur_req = tag;
    cur_sw  = sw;
    addr    = 14'(sw >> 2);
    wdata   = wd;
    wr_en   = we;
    rd_en   = re;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) op(0, 1'b0, 32'h0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 0; rd_en = 0;
    status_in = {32'hD00D_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000};
    repeat (3) @(negedge clk);
    // R1: outputs clear during reset
    chk("R1", "rdata in reset", rdata, 32'h0);
    chk("R1", "ctrl_out in reset", ctrl_out[31:0] | ctrl_out[63:32] | ctrl_out[95:64] | ctrl_out[127:96], 32'h0);
    chk("R1", "ts_reset in reset", {31'b0, ts_reset}, 32'h0);
    rst_n = 1'b1;
    idle(2, "R1");

    // R2: write each control word
    op('h8700, 1, 32'h1111_AAAA, 0, "R2");
    op('h8704, 1, 32'h2222_5555, 0, "R2");
    op('h8708, 1, 32'h3333_0F0E, 0, "R2");
    op('h870C, 1, 32'hFFFF_0000, 0, "R2");
    // R3: read back, then hold with strobe low
    for (int k = 0; k < 4; k++) op('h8700 + 4*k, 0, 32'h0, 1, "R3");
    idle(3, "R3");
    // R4: status words, changing between reads
    for (int j = 0; j < 4; j++) op('h8710 + 4*j, 0, 32'h0, 1, "R4");
    @(negedge clk); status_in = {32'h1234_5678, 32'h8765_4321, 32'h0F0F_F0F0, 32'hFFFF_FFFF};
    for (int j = 3; j >= 0; j--) op('h8710 + 4*j, 0, 32'h0, 1, "R4");
    // R5: writes to status words ignored
    for (int j = 0; j < 4; j++) op('h8710 + 4*j, 1, 32'hDEAD_BEEF, 0, "R5");
    op('h8714, 0, 32'h0, 1, "R5");
    op('h870C, 0, 32'h0, 1, "R5");
    // R6: other banks and unused offsets
    op('h8000, 1, 32'h5A5A_5A5A, 1, "R6");
    op('h8600, 1, 32'h5A5A_5A5A, 1, "R6");
    op('h8800, 1, 32'h5A5A_5A5A, 1, "R6");
    op('h8720, 1, 32'h5A5A_5A5A, 1, "R6");
    op('h87FC, 1, 32'h5A5A_5A5A, 1, "R6");
    op('h8900, 0, 32'h0, 1, "R6");
    // R8: same low bits in other regions
    op('h0708, 1, 32'h0000_0001, 1, "R8");
    op('hC700, 1, 32'h7777_7777, 1, "R8");
    op('h4704, 1, 32'h6666_6666, 1, "R8");
    op('h8708, 0, 32'h0, 1, "R8");
    // R7: timestamp reset bit level
    op('h8708, 1, 32'h0000_0001, 0, "R7");
    idle(4, "R7");
    op('h8708, 1, 32'hFFFF_FFFE, 0, "R7");
    idle(2, "R7");
    op('h8708, 1, 32'h8000_0001, 0, "R7");
    // R9: read and write to the same word in one cycle
    op('h8704, 1, 32'hCAFE_F00D, 1, "R9");
    op('h8704, 0, 32'h0, 1, "R9");
    op('h8700, 1, 32'h0BAD_CAFE, 1, "R9");
    idle(2, "R9");
    // R1: reset taken mid-run
    @(negedge clk); cur_req = "R1"; rst_n = 1'b0;
    #3;
    chk("R1", "rdata after mid reset", rdata, 32'h0);
    chk("R1", "ctrl word 2 after mid reset", ctrl_out[95:64], 32'h0);
    chk("R1", "ts_reset after mid reset", {31'b0, ts_reset}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");
    op('h8704, 0, 32'h0, 1, "R1");
    idle(2, "R1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule